// File: doc/BRIEF.md
# In-order pipeline interlock unit

This block decides, every cycle, whether the instruction sitting in the register-read stage of a five-stage in-order pipeline may move on into execute. The stages run fetch, decode, register-read, execute, writeback. Execute has two separate functional units: a single-cycle add/subtract unit and a non-pipelined multiply unit that needs several execute cycles. Because of this, results can complete out of order. When the block holds the register-read instruction, it also holds fetch and decode, and it sends an empty slot (valid low) into execute in place of the held instruction.

The surrounding pipeline supplies the register-read instruction's two source identifiers, its destination and a multiply flag, plus the valid bit and destination of the add/subtract instruction in execute and of the one in writeback. The block keeps its own count of the execute cycles the multiply still needs, along with that multiply's destination. From the count it knows when the multiply is busy, when its result reaches writeback, and whether a younger add could finish first. Register 0 is the hardwired zero register and never creates a dependence.

Top module: `pipe_interlock`

## Requirements
- R1: When the register-read instruction is valid and either of its source identifiers is nonzero and equal to `ex_dst` while `ex_valid` is high, all four outputs are high in that same cycle.
- R2: When either source is nonzero and equal to `wb_dst` while `wb_valid` is high, all four outputs are high in that cycle. A producer of the add unit therefore costs its consumer one stall cycle in execute plus one in writeback if the consumer follows directly.
- R3: A multiply is issued when it leaves register-read unstalled. An instruction reading that multiply's nonzero destination stalls from then until the multiply's writeback cycle, inclusive. A reader that follows directly stalls MUL_LAT+1 cycles (7 by default).
- R4: Register 0 and slots whose valid bit is low never match. A source or destination of 0 never causes a stall, and neither does a producer identifier carried by an invalid execute or writeback slot.
- R5: A non-multiply instruction whose nonzero destination equals that of the multiply still executing stalls while the multiply needs more than ALU_LAT further execute cycles. A directly following one stalls MUL_LAT-1 cycles (5 by default) and then issues, so it writes back one cycle after the multiply.
- R6: A destination that equals a source of an older instruction (write-after-read), or the destination of an add/subtract instruction in execute or writeback, never causes a stall.
- R7: A multiply in register-read stalls while an issued multiply still has execute cycles left. A multiply directly after another stalls MUL_LAT cycles (6 by default).
- R8: With `rr_valid` low, no output is high. Otherwise `hold_fetch`, `hold_decode`, `hold_regread` and `ex_bubble` are always equal.
- R9: Reset clears the multiply tracking. During reset no output is high. After reset, no instruction stalls on a multiply issued before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_valid | input | 1 | Register-read slot holds an instruction |
| rr_is_mul | input | 1 | Register-read instruction uses the multiply unit |
| rr_src_a | input | REG_W | First source register of the register-read instruction |
| rr_src_b | input | REG_W | Second source register of the register-read instruction |
| rr_dst | input | REG_W | Destination register of the register-read instruction |
| ex_valid | input | 1 | Add/subtract instruction present in execute |
| ex_dst | input | REG_W | Destination of the add/subtract instruction in execute |
| wb_valid | input | 1 | Add/subtract instruction present in writeback |
| wb_dst | input | REG_W | Destination of the add/subtract instruction in writeback |
| hold_fetch | output | 1 | Keep the fetch stage contents |
| hold_decode | output | 1 | Keep the decode stage contents |
| hold_regread | output | 1 | Keep the register-read stage contents |
| ex_bubble | output | 1 | Load an empty slot into execute |

## Verification
The bench targets the exact length of each multiply-related stall. If the multiply count is off by one, a reader leaves register-read one cycle early and reads a stale value, or a same-destination add issues while the multiply's remaining count is still above one and writes back first. The bench sends invalid execute and writeback slots that carry a leftover destination equal to a later source, so a comparator that ignores the valid bit stalls for no reason. It also sends writes to register 0, so a comparator that ignores the zero register stalls as well. A reset arrives in the middle of a multiply, and back-to-back multiplies, write-after-read pairs and a long pseudo-random instruction stream are each compared cycle by cycle against a scoreboard of register-ready times.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Comparator layout: consumers (sources) by producers
  localparam int N_SRC   = 2;
  localparam int N_PROD  = 4;
  localparam int PRD_EX  = 0;  // add/subtract result in execute
  localparam int PRD_WB  = 1;  // add/subtract result in writeback
  localparam int PRD_MEX = 2;  // multiply still executing
  localparam int PRD_MWB = 3;  // multiply result in writeback

  typedef struct packed {
    logic raw;   // read-after-write on any producer
    logic waw;   // write-after-write against the long multiply
    logic busy;  // multiply unit occupied
  } hz_flags_t;
endpackage

// File: rtl/ilk_id_match.sv
module ilk_id_match #(
  parameter int REG_W = 5
) (
  input  logic             prod_vld,
  input  logic [REG_W-1:0] prod_id,
  input  logic [REG_W-1:0] cons_id,
  output logic             hit
);
  // Register 0 and empty producers never match
  always_comb hit = prod_vld && (prod_id != '0) && (prod_id == cons_id);
endmodule

// File: rtl/ilk_mul_track.sv
module ilk_mul_track #(
  parameter int REG_W   = 5,
  parameter int MUL_LAT = 6,
  localparam int CNT_W  = $clog2(MUL_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [REG_W-1:0] issue_dst,
  output logic [CNT_W-1:0] cnt,
  output logic [REG_W-1:0] dst,
  output logic             busy,
  output logic             wb_vld
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REG_W-1:0] dst_q;
  logic             wb_q, wb_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wb_d   = 1'b0;
    cnt_en = issue || (cnt_q != '0);
    if (issue) begin
      cnt_d = CNT_W'(MUL_LAT);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      wb_d  = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dst_q <= '0;
      wb_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (issue)  dst_q <= issue_dst;
      wb_q <= wb_d;
    end
  end

  assign cnt    = cnt_q;
  assign dst    = dst_q;
  assign busy   = (cnt_q != '0);
  assign wb_vld = wb_q;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int REG_W   = 5,
  parameter int MUL_LAT = 6,
  parameter int ALU_LAT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_valid,
  input  logic             rr_is_mul,
  input  logic [REG_W-1:0] rr_src_a,
  input  logic [REG_W-1:0] rr_src_b,
  input  logic [REG_W-1:0] rr_dst,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_dst,
  output logic             hold_fetch,
  output logic             hold_decode,
  output logic             hold_regread,
  output logic             ex_bubble
);
  import ilk_pkg::*;
  localparam int CNT_W = $clog2(MUL_LAT + 1);

  logic [CNT_W-1:0]        mul_cnt;
  logic [REG_W-1:0]        mul_dst;
  logic                    mul_busy, mul_wb, mul_issue;
  logic                    waw_window, waw_hit;
  logic [N_PROD-1:0]       prod_vld;
  logic [REG_W-1:0]        prod_id [N_PROD];
  logic [REG_W-1:0]        src_id  [N_SRC];
  logic [N_SRC*N_PROD-1:0] raw_hit;
  hz_flags_t               hz;
  logic                    stall;

  // Producer table
  always_comb begin
    prod_vld[PRD_EX]  = ex_valid;   prod_id[PRD_EX]  = ex_dst;
    prod_vld[PRD_WB]  = wb_valid;   prod_id[PRD_WB]  = wb_dst;
    prod_vld[PRD_MEX] = mul_busy;   prod_id[PRD_MEX] = mul_dst;
    prod_vld[PRD_MWB] = mul_wb;     prod_id[PRD_MWB] = mul_dst;
    src_id[0] = rr_src_a;
    src_id[1] = rr_src_b;
  end

  // Read-after-write comparators: every source against every producer
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar p = 0; p < N_PROD; p++) begin : g_prod
      ilk_id_match #(.REG_W(REG_W)) u_raw (
        .prod_vld (prod_vld[p]),
        .prod_id  (prod_id[p]),
        .cons_id  (src_id[s]),
        .hit      (raw_hit[s*N_PROD+p])
      );
    end
  end

  // Write-after-write only while the multiply outlasts a single-cycle op
  assign waw_window = mul_busy && (mul_cnt > CNT_W'(ALU_LAT));

  ilk_id_match #(.REG_W(REG_W)) u_waw (
    .prod_vld (waw_window),
    .prod_id  (mul_dst),
    .cons_id  (rr_dst),
    .hit      (waw_hit)
  );

  always_comb begin
    hz.raw  = |raw_hit;
    hz.waw  = waw_hit;
    hz.busy = rr_is_mul && mul_busy;
    stall   = rr_valid && (hz.raw || hz.waw || hz.busy);
    mul_issue = rr_valid && rr_is_mul && !stall;
  end

  ilk_mul_track #(.REG_W(REG_W), .MUL_LAT(MUL_LAT)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (mul_issue),
    .issue_dst (rr_dst),
    .cnt       (mul_cnt),
    .dst       (mul_dst),
    .busy      (mul_busy),
    .wb_vld    (mul_wb)
  );

  assign hold_fetch   = stall;
  assign hold_decode  = stall;
  assign hold_regread = stall;
  assign ex_bubble    = stall;
endmodule

// File: rtl/ilk_chk.sv
module ilk_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rr_valid,
  input logic             rr_is_mul,
  input logic [REG_W-1:0] rr_src_a,
  input logic [REG_W-1:0] rr_src_b,
  input logic [REG_W-1:0] rr_dst,
  input logic             ex_valid,
  input logic [REG_W-1:0] ex_dst,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_dst,
  input logic             hold_fetch,
  input logic             hold_decode,
  input logic             hold_regread,
  input logic             ex_bubble
);
  p_raw_ex_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && ex_valid && ex_dst != '0 && (rr_src_a == ex_dst || rr_src_b == ex_dst))
      |-> hold_regread);

  p_raw_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && wb_valid && wb_dst != '0 && (rr_src_a == wb_dst || rr_src_b == wb_dst))
      |-> hold_regread);

  p_raw_mul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && rr_is_mul && !hold_regread && rr_dst != '0)
      |=> (!(rr_valid && (rr_src_a == $past(rr_dst) || rr_src_b == $past(rr_dst))) || hold_regread));

  p_zero_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && !rr_is_mul && rr_src_a == '0 && rr_src_b == '0 && rr_dst == '0)
      |-> !hold_regread);

  p_waw_mul_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && rr_is_mul && !hold_regread && rr_dst != '0)
      |=> (!(rr_valid && rr_dst == $past(rr_dst)) || hold_regread));

  p_mul_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && rr_is_mul && !hold_regread)
      |=> (!(rr_valid && rr_is_mul) || hold_regread));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_valid |-> !(hold_fetch || hold_decode || hold_regread || ex_bubble));

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hold_fetch, hold_decode, hold_regread, ex_bubble}) inside {0, 4});
endmodule

bind pipe_interlock ilk_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rr_valid     (rr_valid),
  .rr_is_mul    (rr_is_mul),
  .rr_src_a     (rr_src_a),
  .rr_src_b     (rr_src_b),
  .rr_dst       (rr_dst),
  .ex_valid     (ex_valid),
  .ex_dst       (ex_dst),
  .wb_valid     (wb_valid),
  .wb_dst       (wb_dst),
  .hold_fetch   (hold_fetch),
  .hold_decode  (hold_decode),
  .hold_regread (hold_regread),
  .ex_bubble    (ex_bubble)
);

// File: tb/tb_pipe_interlock.sv
`timescale 1ns/1ps
module tb_pipe_interlock;
  localparam int REG_W   = 5;
  localparam int MUL_LAT = 6;
  localparam int NREG    = 1 << REG_W;

  logic clk, rst_n;
  logic rr_valid, rr_is_mul;
  logic [REG_W-1:0] rr_src_a, rr_src_b, rr_dst, ex_dst, wb_dst;
  logic ex_valid, wb_valid;
  logic hold_fetch, hold_decode, hold_regread, ex_bubble;

  pipe_interlock #(.REG_W(REG_W), .MUL_LAT(MUL_LAT), .ALU_LAT(1)) dut (
    .clk(clk), .rst_n(rst_n), .rr_valid(rr_valid), .rr_is_mul(rr_is_mul),
    .rr_src_a(rr_src_a), .rr_src_b(rr_src_b), .rr_dst(rr_dst),
    .ex_valid(ex_valid), .ex_dst(ex_dst), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .hold_fetch(hold_fetch), .hold_decode(hold_decode),
    .hold_regread(hold_regread), .ex_bubble(ex_bubble)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    bit    v;
    bit    m;
    int    a;
    int    b;
    int    d;
    string lab;
  } tok_t;

  tok_t prog[$];
  int   n_cmp, n_bad, cyc, busy_until;
  int   wbc [NREG];          // cycle in which each register is last written back
  bit   m_ex_v, m_wb_v;
  int   m_ex_d, m_wb_d;
  bit   done;

  task automatic add(bit m, int d, int a, int b, string lab);
    tok_t t;
    t.v = 1'b1; t.m = m; t.a = a; t.b = b; t.d = d; t.lab = lab;
    prog.push_back(t);
  endtask

  task automatic gap(string lab);
    tok_t t;
    t.v = 1'b0; t.m = 1'b0; t.a = 0; t.b = 0; t.d = 0; t.lab = lab;
    prog.push_back(t);
  endtask

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) wbc[r] = -100;
    busy_until = -100;
    m_ex_v = 1'b0; m_ex_d = 0; m_wb_v = 1'b0; m_wb_d = 0;
  endtask

  task automatic check(string lab, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", lab, cyc, act, exp);
    end
  endtask

  // One pipeline cycle of the reference model
  task automatic step();
    tok_t t;
    bit   have, raw, waw, struc, exp;
    int   lat;
    @(negedge clk);
    have = (prog.size() > 0);
    if (have) t = prog[0];
    else begin t.v = 1'b0; t.m = 1'b0; t.a = 0; t.b = 0; t.d = 0; t.lab = "R8"; end
    rr_valid = t.v; rr_is_mul = t.m;
    rr_src_a = REG_W'(t.a); rr_src_b = REG_W'(t.b); rr_dst = REG_W'(t.d);
    ex_valid = m_ex_v; ex_dst = REG_W'(m_ex_d);
    wb_valid = m_wb_v; wb_dst = REG_W'(m_wb_d);
    #1;
    lat   = t.m ? MUL_LAT : 1;
    raw   = (t.a != 0 && cyc <= wbc[t.a]) || (t.b != 0 && cyc <= wbc[t.b]);
    waw   = (t.d != 0 && wbc[t.d] >= cyc + 1 + lat);
    struc = t.m && (cyc <= busy_until);
    exp   = t.v && (raw || waw || struc);
    check(t.lab, {hold_fetch, hold_decode, hold_regread, ex_bubble}, {4{exp}});
    // advance the model
    m_wb_v = m_ex_v; m_wb_d = m_ex_d;
    m_ex_v = 1'b0;   m_ex_d = t.a;   // empty slot keeps a leftover identifier
    if (!exp) begin
      if (t.v) begin
        if (t.m) begin
          busy_until = cyc + MUL_LAT;
          if (t.d != 0) wbc[t.d] = cyc + MUL_LAT + 1;
        end else begin
          m_ex_v = 1'b1; m_ex_d = t.d;
          if (t.d != 0) wbc[t.d] = cyc + 2;
        end
      end
      if (have) void'(prog.pop_front());
    end
    cyc++;
  endtask

  task automatic run(int drain);
    while (prog.size() > 0) step();
    repeat (drain) step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rr_valid = 1'b0; ex_valid = 1'b0; wb_valid = 1'b0;
    model_clear();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 check("R9 reset", {hold_fetch, hold_decode, hold_regread, ex_bubble}, 4'b0000);
      cyc++;
    end
    rst_n = 1'b1;
  endtask

  initial begin
    int unsigned lf;
    n_cmp = 0; n_bad = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; rr_valid = 1'b0; rr_is_mul = 1'b0;
    rr_src_a = '0; rr_src_b = '0; rr_dst = '0;
    ex_valid = 1'b0; ex_dst = '0; wb_valid = 1'b0; wb_dst = '0;
    model_clear();
    do_reset();

    // R9: fresh state, nothing outstanding
    add(0, 1, 2, 3, "R9 after reset");
    add(1, 2, 3, 4, "R9 after reset");
    run(10);

    // R1: consumer directly behind producer (source b), stalls on execute then writeback
    add(0, 4, 1, 1, "R1 producer");
    add(0, 5, 2, 4, "R1 src_b on execute");
    add(0, 6, 5, 0, "R1 src_a on execute");
    // R2: one instruction between producer and consumer
    add(0, 7, 1, 2, "R2 producer");
    add(0, 8, 1, 2, "R2 filler");
    add(0, 9, 7, 7, "R2 on writeback");
    run(4);

    // R3: reader directly after multiply
    add(1, 8, 1, 2, "R3 multiply");
    add(0, 9, 8, 1, "R3 reader of multiply");
    run(4);
    // R3 with a gap before the reader
    add(1, 11, 1, 2, "R3 multiply");
    gap("R8 empty slot during multiply");
    gap("R8 empty slot during multiply");
    add(0, 12, 3, 11, "R3 late reader");
    run(4);

    // R5: same destination as the running multiply
    add(1, 10, 1, 2, "R5 multiply");
    add(0, 10, 3, 4, "R5 write after write");
    add(0, 13, 10, 0, "R5 reader after reorder");
    run(4);

    // R7: back-to-back multiplies, then a dependent multiply
    add(1, 14, 1, 2, "R7 multiply");
    add(1, 15, 3, 4, "R7 busy unit");
    add(1, 16, 15, 1, "R7 dependent multiply");
    run(12);

    // R4: writes to register 0 and leftover identifiers in empty slots
    add(0, 0, 1, 2, "R4 write to r0");
    add(0, 3, 0, 0, "R4 reads r0");
    add(1, 17, 1, 2, "R4 multiply");
    add(0, 18, 17, 0, "R4 stalled reader");
    add(0, 19, 17, 17, "R4 invalid slot with old id");
    add(0, 20, 17, 0, "R4 invalid slot with old id");
    run(4);

    // R6: write after read and same destination as add unit producers
    add(0, 21, 22, 23, "R6 older reader");
    add(0, 22, 1, 2, "R6 write after read");
    add(0, 22, 3, 4, "R6 write after write on add");
    add(0, 24, 1, 1, "R6 filler");
    add(0, 22, 5, 6, "R6 same dst as writeback");
    run(4);

    // R8: empty slots while producers are active
    add(0, 25, 1, 2, "R8 producer");
    gap("R8 empty behind producer");
    gap("R8 empty behind producer");
    run(2);

    // R9: reset in the middle of a multiply
    add(1, 26, 1, 2, "R9 multiply before reset");
    run(0);
    do_reset();
    add(0, 27, 26, 26, "R9 reader after reset");
    add(1, 28, 1, 2, "R9 multiply after reset");
    add(0, 26, 1, 2, "R9 dst after reset");
    run(10);

    // Mixed stream on a small register set
    lf = 32'hACE1_1357;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[13:11] == 3'd0) gap("MIX R8");
      else add(lf[10:9] == 2'd0, int'(lf[2:0]), int'(lf[5:3]), int'(lf[8:6]),
               "MIX R1 R2 R3 R5 R7");
    end
    run(12);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule